// File: doc/BRIEF.md
# HBA Global Register Bank

This block holds the adapter-wide registers of a multi-port SATA host bus adapter. Software reaches it through a simple single-cycle 32-bit register bus. Through that bus it reads a capability word that reports how many ports and command slots the adapter was built with, and a bitmap of the ports that physically exist. It also programs a control word that carries an AHCI mode enable and a global interrupt enable, and it sets a secondary port-enable mask.

Each port raises a level-sensitive pending input. The bank folds these inputs into a per-port summary status word. Software clears the status by writing ones to its bits. A single interrupt line is raised whenever any summary bit is set and the global interrupt enable is on. Counts in the capability word are encoded as the count minus one.

Top module: `hba_glb_regs`

## Requirements
- R1: After reset the control word, the status word, the port-enable mask, `bus_rdata` and `irq` are all zero.
- R2: Word offset 0 (capability) reads with bits [4:0] = port count minus one, bits [12:8] = command-slot count minus one, and all other bits zero. Writes to it have no effect.
- R3: Word offset 3 (ports present) reads as the build-time bitmap, in which bit i set means port i exists, limited to the port count. Writes to it have no effect.
- R4: Word offset 1 (control) holds bit 0 = AHCI mode enable and bit 1 = interrupt enable. Each bit reads back as written, and bits [31:2] read as zero.
- R5: A status bit at word offset 2 becomes 1 one clock after a present port's pending input is high. Pending inputs of absent ports never set a status bit.
- R6: Writing a word to offset 2 clears every status bit whose data bit is 1. Bits written with 0 keep their value, and writes to other offsets never clear status.
- R7: When a cleared port's pending input is still high during the clearing write, its status bit reads 0 for one cycle and is set again on the next clock.
- R8: `irq` is high exactly when the interrupt-enable bit is 1 and at least one status bit is 1.
- R9: Word offset 4 (port-enable mask) stores the low 8 bits of a write and reads them back. Bits [31:8] read as zero. Setting bits [5:0] enables ports 0 to 5.
- R10: Offsets 5 to 15 read as zero, and writes to them change no register.
- R11: A read (`bus_sel`=1, `bus_wr`=0) loads `bus_rdata` at the clock edge with the register value held before that edge. Without a read, `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the clock after a read |
| port_pend | input | 6 | Per-port interrupt-pending levels |
| irq | output | 1 | Adapter interrupt line |

## Verification
The assertions assume that `port_pend` and the bus inputs are stable around the rising clock edge. They also assume that each access lasts one cycle with a defined `bus_addr` and `bus_wr` whenever `bus_sel` is high. The stimulus drives every input on the falling edge only, so each value is held for the whole cycle. Random accesses pick any of the 16 offsets, including undecoded ones, with arbitrary data. Random pending vectors include the absent-port bits, so the masking and the clear-versus-pending race are exercised against a bench model that follows the requirements.

// File: rtl/hba_glb_pkg.sv
`timescale 1ns/1ps
package hba_glb_pkg;

    // Word offsets of the decoded registers
    localparam int unsigned OFF_CAP  = 0;
    localparam int unsigned OFF_CTL  = 1;
    localparam int unsigned OFF_STAT = 2;
    localparam int unsigned OFF_PI   = 3;
    localparam int unsigned OFF_PEN  = 4;

    // Bit positions inside the control word
    localparam int unsigned CTL_AHCI_BIT = 0;
    localparam int unsigned CTL_IRQ_BIT  = 1;

    // Capability field placement
    localparam int unsigned CAP_NP_LSB = 0;
    localparam int unsigned CAP_NS_LSB = 8;
    localparam int unsigned CAP_FLD_W  = 5;

    // Access decode result
    typedef enum logic [2:0] {
        SEL_CAP,
        SEL_CTL,
        SEL_STAT,
        SEL_PI,
        SEL_PEN,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [3:0] off);
        reg_sel_e s;
        case (off)
            4'(OFF_CAP):  s = SEL_CAP;
            4'(OFF_CTL):  s = SEL_CTL;
            4'(OFF_STAT): s = SEL_STAT;
            4'(OFF_PI):   s = SEL_PI;
            4'(OFF_PEN):  s = SEL_PEN;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hba_cap_const.sv
`timescale 1ns/1ps
module hba_cap_const
    import hba_glb_pkg::*;
#(
    parameter int unsigned NPORTS     = 6,
    parameter int unsigned NSLOTS     = 32,
    parameter logic [31:0] PORTS_IMPL = 32'h0000_002D
) (
    output logic [31:0] cap_word,
    output logic [31:0] pi_word
);
    localparam logic [CAP_FLD_W-1:0] NP_FIELD = CAP_FLD_W'(NPORTS - 1);
    localparam logic [CAP_FLD_W-1:0] NS_FIELD = CAP_FLD_W'(NSLOTS - 1);

    // Ports beyond the built count are forced absent
    logic [31:0] port_lim;

    generate
        for (genvar g = 0; g < 32; g++) begin : g_lim
            if (g < NPORTS) begin : g_in
                assign port_lim[g] = 1'b1;
            end else begin : g_out
                assign port_lim[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        cap_word = '0;
        cap_word[CAP_NP_LSB +: CAP_FLD_W] = NP_FIELD;
        cap_word[CAP_NS_LSB +: CAP_FLD_W] = NS_FIELD;
        pi_word = PORTS_IMPL & port_lim;
    end

endmodule

// File: rtl/hba_isr_bank.sv
`timescale 1ns/1ps
module hba_isr_bank #(
    parameter int unsigned     NPORTS = 6,
    parameter logic [NPORTS-1:0] PMASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] pend,
    input  logic [NPORTS-1:0] clr,
    output logic [NPORTS-1:0] status
);
    logic [NPORTS-1:0] stat_d, stat_q;

    // A bit being cleared ignores its pending input this cycle, so a
    // still-pending port shows one idle cycle before re-setting.
    always_comb begin
        for (int i = 0; i < NPORTS; i++) begin
            if (clr[i]) begin
                stat_d[i] = 1'b0;
            end else begin
                stat_d[i] = stat_q[i] | (pend[i] & PMASK[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status = stat_q;

endmodule

// File: rtl/hba_rd_mux.sv
`timescale 1ns/1ps
module hba_rd_mux
    import hba_glb_pkg::*;
(
    input  reg_sel_e    sel,
    input  logic [31:0] cap_word,
    input  logic [31:0] ctl_word,
    input  logic [31:0] stat_word,
    input  logic [31:0] pi_word,
    input  logic [31:0] pen_word,
    output logic [31:0] rd_word
);
    always_comb begin
        case (sel)
            SEL_CAP:  rd_word = cap_word;
            SEL_CTL:  rd_word = ctl_word;
            SEL_STAT: rd_word = stat_word;
            SEL_PI:   rd_word = pi_word;
            SEL_PEN:  rd_word = pen_word;
            default:  rd_word = '0;
        endcase
    end

endmodule

// File: rtl/hba_glb_regs.sv
`timescale 1ns/1ps
module hba_glb_regs
    import hba_glb_pkg::*;
#(
    parameter int unsigned NPORTS     = 6,
    parameter int unsigned NSLOTS     = 32,
    parameter logic [31:0] PORTS_IMPL = 32'h0000_002D,
    parameter int unsigned PEN_W      = 8,
    parameter int unsigned ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPORTS-1:0] port_pend,
    output logic              irq
);
    localparam logic [NPORTS-1:0] PMASK = PORTS_IMPL[NPORTS-1:0];

    typedef struct packed {
        logic             ahci_en;
        logic             irq_en;
        logic [PEN_W-1:0] pen;
        logic [31:0]      rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [31:0]       cap_word, pi_word, ctl_word, stat_word, pen_word, rd_word;
    logic [NPORTS-1:0] stat_vec;
    logic [NPORTS-1:0] clr_vec;
    logic              irq_en;
    reg_sel_e          sel;
    logic              wr_stb, rd_stb;
    logic              unused_wbits;

    assign sel    = decode_offset(4'(bus_addr));
    assign wr_stb = bus_sel & bus_wr;
    assign rd_stb = bus_sel & ~bus_wr;

    hba_cap_const #(
        .NPORTS    (NPORTS),
        .NSLOTS    (NSLOTS),
        .PORTS_IMPL(PORTS_IMPL)
    ) u_cap (
        .cap_word(cap_word),
        .pi_word (pi_word)
    );

    assign clr_vec = (wr_stb && sel == SEL_STAT) ? (bus_wdata[NPORTS-1:0] & PMASK) : '0;

    hba_isr_bank #(
        .NPORTS(NPORTS),
        .PMASK (PMASK)
    ) u_isr (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (port_pend),
        .clr   (clr_vec),
        .status(stat_vec)
    );

    always_comb begin
        ctl_word = '0;
        ctl_word[CTL_AHCI_BIT] = st_q.ahci_en;
        ctl_word[CTL_IRQ_BIT]  = st_q.irq_en;
        stat_word = 32'(stat_vec);
        pen_word  = 32'(st_q.pen);
    end

    hba_rd_mux u_rd (
        .sel      (sel),
        .cap_word (cap_word),
        .ctl_word (ctl_word),
        .stat_word(stat_word),
        .pi_word  (pi_word),
        .pen_word (pen_word),
        .rd_word  (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (wr_stb && sel == SEL_CTL) begin
            st_d.ahci_en = bus_wdata[CTL_AHCI_BIT];
            st_d.irq_en  = bus_wdata[CTL_IRQ_BIT];
        end
        if (wr_stb && sel == SEL_PEN) begin
            st_d.pen = bus_wdata[PEN_W-1:0];
        end
        if (rd_stb) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_en       = st_q.irq_en;
    assign irq          = irq_en & (|stat_vec);
    assign bus_rdata    = st_q.rdata;
    assign unused_wbits = ^{1'b0, bus_wdata};

endmodule

// File: rtl/hba_glb_chk.sv
`timescale 1ns/1ps
module hba_glb_chk #(
    parameter int unsigned NPORTS     = 6,
    parameter logic [31:0] PORTS_IMPL = 32'h0000_002D,
    parameter int unsigned ADDR_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NPORTS-1:0] port_pend,
    input logic              irq,
    input logic [NPORTS-1:0] stat_vec,
    input logic              irq_en
);
    localparam logic [NPORTS-1:0] PM = PORTS_IMPL[NPORTS-1:0];

    logic stat_wr;
    assign stat_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));

    // R5: pending on a present port without a status write sets the bit
    assert_pend_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(port_pend & PM) && !stat_wr) |=>
            ((stat_vec & $past(port_pend & PM)) == $past(port_pend & PM)));

    // R5: absent ports never hold status
    assert_absent_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_vec & ~PM) == '0));

    // R6: every bit written with 1 is zero after the write
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((stat_vec & $past(bus_wdata[NPORTS-1:0])) == '0));

    // R8: no interrupt while disabled or with empty status
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || stat_vec == '0) |-> !irq);

    // R11: read data holds without a read
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind hba_glb_regs hba_glb_chk #(
    .NPORTS    (NPORTS),
    .PORTS_IMPL(PORTS_IMPL),
    .ADDR_W    (ADDR_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .port_pend(port_pend),
    .irq      (irq),
    .stat_vec (stat_vec),
    .irq_en   (irq_en)
);

// File: tb/test_hba_glb_regs.sv
`timescale 1ns/1ps
module test_hba_glb_regs;
    localparam logic [31:0] EXP_CAP = 32'h0000_1F05;  // 6 ports, 32 slots
    localparam logic [5:0]  EXP_PI  = 6'h2D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  port_pend = '0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    // bench model
    logic       m_ahci, m_ien;
    logic [7:0] m_pen;
    logic [5:0] m_stat;
    logic [31:0] m_rd;

    always #10 clk = ~clk;

    hba_glb_regs i_hba_glb_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_pend(port_pend), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [3:0] a);
        case (a)
            4'd0: return EXP_CAP;
            4'd1: return {30'd0, m_ien, m_ahci};
            4'd2: return {26'd0, m_stat};
            4'd3: return {26'd0, EXP_PI};
            4'd4: return {24'd0, m_pen};
            default: return 32'd0;
        endcase
    endfunction

    // One bus cycle; called at a falling edge, returns at the next one
    task automatic step(bit sel, bit wr, logic [3:0] a, logic [31:0] d,
                        logic [5:0] p, string tag);
        logic [5:0] clr;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; port_pend = p;
        if (sel && !wr) m_rd = model_read(a);
        clr = (sel && wr && a == 4'd2) ? (d[5:0] & EXP_PI) : 6'd0;
        m_stat = (m_stat | (p & EXP_PI & ~clr)) & ~clr;
        if (sel && wr && a == 4'd1) begin m_ahci = d[0]; m_ien = d[1]; end
        if (sel && wr && a == 4'd4) m_pen = d[7:0];
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        check({tag, " R11 rdata"}, bus_rdata, m_rd);
        check({tag, " R8 irq"}, {31'd0, irq}, {31'd0, m_ien & (|m_stat)});
    endtask

    task automatic rd(logic [3:0] a, logic [5:0] p, string tag, logic [31:0] exp);
        step(1, 0, a, 32'd0, p, tag);
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ahci = 0; m_ien = 0; m_pen = 0; m_stat = 0; m_rd = 0;
        repeat (3) @(negedge clk);
        check("R1 rdata at reset", bus_rdata, 0);
        check("R1 irq at reset", {31'd0, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // reset contents
        rd(4'd1, 0, "R1 control reset", 0);
        rd(4'd2, 0, "R1 status reset", 0);
        rd(4'd4, 0, "R1 mask reset", 0);
        rd(4'd0, 0, "R2 capability", EXP_CAP);
        rd(4'd3, 0, "R3 ports present", 32'h2D);

        // read-only words ignore writes
        step(1, 1, 4'd0, 32'hFFFF_FFFF, 0, "R2 write cap");
        rd(4'd0, 0, "R2 cap after write", EXP_CAP);
        step(1, 1, 4'd3, 32'h0000_0012, 0, "R3 write pi");
        rd(4'd3, 0, "R3 pi after write", 32'h2D);

        // control bits
        step(1, 1, 4'd1, 32'h0000_0001, 0, "R4 set ahci");
        rd(4'd1, 0, "R4 ahci readback", 32'h1);
        step(1, 1, 4'd1, 32'hFFFF_FFFF, 0, "R4 set all");
        rd(4'd1, 0, "R4 both bits readback", 32'h3);

        // port-enable mask
        step(1, 1, 4'd4, 32'h0000_003F, 0, "R9 ports 0-5");
        rd(4'd4, 0, "R9 low six readback", 32'h3F);
        step(1, 1, 4'd4, 32'hFFFF_FFFF, 0, "R9 all ones");
        rd(4'd4, 0, "R9 width limit", 32'hFF);

        // undecoded offsets
        step(1, 1, 4'd7, 32'hFFFF_FFFF, 0, "R10 write hole");
        rd(4'd7, 0, "R10 hole reads zero", 0);
        rd(4'd15, 0, "R10 top hole reads zero", 0);
        rd(4'd4, 0, "R10 mask untouched", 32'hFF);

        // absent port pending ignored (bit 1 absent)
        step(0, 0, 0, 0, 6'b000010, "R5 absent pend");
        check("R5 absent no irq", {31'd0, irq}, 0);
        rd(4'd2, 0, "R5 absent no status", 0);

        // present port sets status and irq
        step(0, 0, 0, 0, 6'b000001, "R5 pend port0");
        check("R8 irq on status", {31'd0, irq}, 1);
        rd(4'd2, 0, "R5 status port0", 32'h1);

        // W1C with zero data keeps bit; write elsewhere keeps bit
        step(1, 1, 4'd2, 32'h0000_0000, 0, "R6 write zero");
        step(1, 1, 4'd4, 32'h0000_0001, 0, "R6 other offset");
        rd(4'd2, 0, "R6 bit kept", 32'h1);

        // irq gate off
        step(1, 1, 4'd1, 32'h0000_0001, 0, "R8 disable irq");
        check("R8 irq gated", {31'd0, irq}, 0);
        step(1, 1, 4'd1, 32'h0000_0003, 0, "R8 enable irq");
        check("R8 irq back", {31'd0, irq}, 1);

        // clear while pending held: zero one cycle, then set again
        step(1, 1, 4'd2, 32'h0000_0001, 6'b000001, "R7 clear pending");
        check("R7 irq low after clear", {31'd0, irq}, 0);
        rd(4'd2, 6'b000001, "R7 reads zero once", 0);
        rd(4'd2, 0, "R7 re-asserted", 32'h1);
        step(1, 1, 4'd2, 32'hFFFF_FFFF, 0, "R6 clear all");
        rd(4'd2, 0, "R6 cleared", 0);

        // R11 hold over idle cycles
        rd(4'd0, 0, "R11 load", EXP_CAP);
        repeat (3) step(0, 0, 4'd1, 0, 0, "R11 hold");
        check("R11 held", bus_rdata, EXP_CAP);

        // constrained random
        for (int k = 0; k < 600; k++) begin
            int unsigned op;
            logic [3:0]  a;
            logic [31:0] d;
            logic [5:0]  p;
            op = $urandom % 6;
            a  = (op < 2) ? 4'($urandom % 16) : 4'($urandom % 5);
            d  = $urandom;
            p  = ($urandom % 3 == 0) ? 6'($urandom) : 6'd0;
            if (op == 5) a = 4'd2;
            case (op)
                0, 2, 5: step(1, 1, a, d, p, "R6 rand write");
                1, 3:    step(1, 0, a, d, p, "R5 rand read");
                default: step(0, 0, a, d, p, "R7 rand idle");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule